// File: doc/BRIEF.md
# Angle Snapshot Hold and Byte-Wide Bus Readout

This block sits between a continuously updating angle tracking counter and an 8-bit host data bus that other devices share. The tracking counter is modelled as a word input with a valid strobe. The block keeps the newest complete word. An output latch normally follows that word, and it freezes a snapshot while the host holds the active-low inhibit input low. Tracking carries on underneath the frozen copy, so the host can read a stable value while the angle keeps changing.

The host reads the angle one byte at a time. Each byte has its own active-low enable. The block presents the byte on `bus_dout` and marks the bus as driven with `bus_oe`. The tri-state pad sits outside the block and turns high impedance whenever `bus_oe` is low. Three parameters set the timing from inhibit to valid data, from enable to drive, and from release to high impedance, each as a whole number of clock cycles.

Top module: `angle_hold_bus`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `bus_oe`, `bus_dout`, `bus_conflict` and `track_word` are all zero.
- R2: While inhibit is high and an enable is held, `bus_dout` after clock edge k carries the selected byte of the newest complete word as of edge k-1.
- R3: Every word presented with `live_valid` high appears on `track_word` after that edge, whether or not inhibit is asserted.
- R4: While inhibit stays low, the held snapshot does not change. Both bytes read during one inhibit period come from the same word.
- R5: Count the first edge that samples `inh_n` low as edge 1. The snapshot is the newest complete word as of edge INH_LAT-1. `bus_dout` shows that snapshot from edge INH_LAT onward.
- R6: The high byte is angle bits [ANGLE_W-1:ANGLE_W-8]. The low byte holds the remaining ANGLE_W-8 bits placed at its top, with the unused low bits zero. With ANGLE_W=12 and word 0xA5C, the bytes are 0xA5 and 0xC0.
- R7: `bus_oe` stays low when no enable has been asserted since reset or since the last release completed. While `bus_oe` is low, `bus_dout` is zero.
- R8: `bus_oe` rises on the EN_LAT-th consecutive edge that samples an enable asserted, and the byte is valid on that same edge. It never rises earlier.
- R9: `bus_oe` falls on the DIS_LAT-th consecutive edge that samples both enables released. It stays high before that edge.
- R10: When both enables are low, `bus_conflict` is high in that same cycle and the high byte is the one driven. With only one enable low, `bus_conflict` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| live_angle | input | ANGLE_W | Angle word from the tracking counter |
| live_valid | input | 1 | High when `live_angle` is a complete new word |
| inh_n | input | 1 | Active-low inhibit: freeze the output snapshot |
| en_hi_n | input | 1 | Active-low enable for the high byte |
| en_lo_n | input | 1 | Active-low enable for the low byte |
| bus_dout | output | 8 | Byte presented to the tri-state pad |
| bus_oe | output | 1 | Pad drive enable; low means high impedance |
| bus_conflict | output | 1 | Both enables asserted in this cycle |
| track_word | output | ANGLE_W | Newest complete tracked word |

## Verification
The hardest case to reach is a snapshot taken while the stream is still changing. Here both bytes must be read back under a single inhibit while new words keep arriving, and the capture edge sits several synchronizer stages behind the inhibit pin. The bench runs a random stream in which most cycles carry a valid word. It keeps a history of the newest complete word at every edge and picks the expected snapshot by counting edges from the moment inhibit was driven. It then swaps from one byte enable to the other without a gap, so both bytes are compared against that one history entry.

// File: rtl/angle_hold_pkg.sv
package angle_hold_pkg;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_HI   = 2'd1,
        SEL_LO   = 2'd2
    } byte_sel_e;

    // High-byte enable wins when both are asserted.
    function automatic byte_sel_e pick_byte(input logic hi_n, input logic lo_n);
        if (!hi_n)      return SEL_HI;
        else if (!lo_n) return SEL_LO;
        else            return SEL_NONE;
    endfunction

endpackage

// File: rtl/inh_sync.sv
module inh_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inh_n,
    output logic inh_s
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain = (st_q.chain << 1) | STAGES'(inh_n);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{chain: '1};
        else        st_q <= st_d;
    end

    assign inh_s = st_q.chain[STAGES-1];
endmodule

// File: rtl/snap_latch.sv
module snap_latch #(
    parameter int ANGLE_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ANGLE_W-1:0] live_angle,
    input  logic               live_valid,
    input  logic               inh_s,
    output logic [ANGLE_W-1:0] track_word,
    output logic [ANGLE_W-1:0] hold_word
);
    typedef struct packed {
        logic [ANGLE_W-1:0] sample;
        logic [ANGLE_W-1:0] hold;
        logic               inh_prev;
    } snap_state_t;

    snap_state_t st_d, st_q;
    logic [ANGLE_W-1:0] newest;

    always_comb begin
        st_d = st_q;
        newest = live_valid ? live_angle : st_q.sample;
        st_d.sample = newest;
        // Follow while released; the first low edge also captures.
        if (inh_s || st_q.inh_prev) st_d.hold = newest;
        st_d.inh_prev = inh_s;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{sample: '0, hold: '0, inh_prev: 1'b1};
        else        st_q <= st_d;
    end

    assign track_word = st_q.sample;
    assign hold_word  = st_q.hold;

    assert_tracks_under_inhibit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        live_valid |=> track_word == $past(live_angle));

    assert_snapshot_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!inh_s && !st_q.inh_prev) |=> $stable(hold_word));
endmodule

// File: rtl/byte_drv.sv
module byte_drv
    import angle_hold_pkg::*;
#(
    parameter int ANGLE_W = 16,
    parameter int EN_LAT  = 2,
    parameter int DIS_LAT = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ANGLE_W-1:0] hold_word,
    input  logic               en_hi_n,
    input  logic               en_lo_n,
    output logic [7:0]         bus_dout,
    output logic               bus_oe,
    output logic               bus_conflict
);
    localparam int LO_W  = ANGLE_W - 8;
    localparam int ON_W  = $clog2(EN_LAT + 1);
    localparam int OFF_W = $clog2(DIS_LAT + 1);

    typedef struct packed {
        logic             oe;
        logic [ON_W-1:0]  on_cnt;
        logic [OFF_W-1:0] off_cnt;
        logic [7:0]       data;
    } drv_state_t;

    drv_state_t st_d, st_q;
    byte_sel_e  sel;
    logic       en_any;
    logic [7:0] hi_byte, lo_byte;

    always_comb begin
        hi_byte = hold_word[ANGLE_W-1 -: 8];
        lo_byte = '0;
        lo_byte[7 -: LO_W] = hold_word[LO_W-1:0];
    end

    always_comb begin
        st_d   = st_q;
        sel    = pick_byte(en_hi_n, en_lo_n);
        en_any = (sel != SEL_NONE);
        case (sel)
            SEL_HI:  st_d.data = hi_byte;
            SEL_LO:  st_d.data = lo_byte;
            default: st_d.data = st_q.data;
        endcase
        if (en_any) begin
            st_d.off_cnt = '0;
            if (!st_q.oe) begin
                st_d.on_cnt = st_q.on_cnt + 1'b1;
                if (st_q.on_cnt + 1'b1 == ON_W'(EN_LAT)) begin
                    st_d.oe     = 1'b1;
                    st_d.on_cnt = '0;
                end
            end
        end else begin
            st_d.on_cnt = '0;
            if (st_q.oe) begin
                st_d.off_cnt = st_q.off_cnt + 1'b1;
                if (st_q.off_cnt + 1'b1 == OFF_W'(DIS_LAT)) begin
                    st_d.oe      = 1'b0;
                    st_d.off_cnt = '0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_oe       = st_q.oe;
    assign bus_dout     = st_q.oe ? st_q.data : 8'h00;
    assign bus_conflict = !en_hi_n && !en_lo_n;

    assert_drive_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe) |-> $past(!en_hi_n || !en_lo_n));

    assert_release_before_float_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_oe) |-> $past(en_hi_n && en_lo_n));

    assert_high_byte_priority_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_hi_n && !en_lo_n) |=> st_q.data == $past(hi_byte));
endmodule

// File: rtl/angle_hold_bus.sv
module angle_hold_bus #(
    parameter int ANGLE_W = 16,
    parameter int INH_LAT = 4,
    parameter int EN_LAT  = 2,
    parameter int DIS_LAT = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ANGLE_W-1:0] live_angle,
    input  logic               live_valid,
    input  logic               inh_n,
    input  logic               en_hi_n,
    input  logic               en_lo_n,
    output logic [7:0]         bus_dout,
    output logic               bus_oe,
    output logic               bus_conflict,
    output logic [ANGLE_W-1:0] track_word
);
    // Snapshot capture and byte register use two edges; the rest is synchronizer.
    localparam int SYNC_STAGES = INH_LAT - 2;

    logic               inh_s;
    logic [ANGLE_W-1:0] hold_word;

    inh_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .inh_n (inh_n),
        .inh_s (inh_s)
    );

    snap_latch #(.ANGLE_W(ANGLE_W)) u_snap (
        .clk        (clk),
        .rst_n      (rst_n),
        .live_angle (live_angle),
        .live_valid (live_valid),
        .inh_s      (inh_s),
        .track_word (track_word),
        .hold_word  (hold_word)
    );

    byte_drv #(.ANGLE_W(ANGLE_W), .EN_LAT(EN_LAT), .DIS_LAT(DIS_LAT)) u_drv (
        .clk          (clk),
        .rst_n        (rst_n),
        .hold_word    (hold_word),
        .en_hi_n      (en_hi_n),
        .en_lo_n      (en_lo_n),
        .bus_dout     (bus_dout),
        .bus_oe       (bus_oe),
        .bus_conflict (bus_conflict)
    );

    assert_quiet_when_floating_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> bus_dout == 8'h00);
endmodule

// File: tb/tb_angle_hold_bus.sv
module tb_angle_hold_bus;
    localparam int W       = 16;
    localparam int INH_LAT = 4;
    localparam int EN_LAT  = 2;
    localparam int DIS_LAT = 3;

    logic clk = 1'b0;
    logic rst_n;
    logic [W-1:0] live_angle;
    logic live_valid;
    logic inh_n, en_hi_n, en_lo_n;
    logic [7:0] bus_dout;
    logic bus_oe, bus_conflict;
    logic [W-1:0] track_word;

    logic [11:0] live12;
    logic valid12, en_hi12_n, en_lo12_n;
    logic inh12_n;
    logic [7:0] dout12;
    logic oe12, conf12;
    logic [11:0] track12;

    int checks = 0;
    int fails  = 0;
    bit stream_on = 1'b0;

    always #5 clk = ~clk;

    angle_hold_bus #(.ANGLE_W(W), .INH_LAT(INH_LAT), .EN_LAT(EN_LAT), .DIS_LAT(DIS_LAT)) dut (
        .clk(clk), .rst_n(rst_n), .live_angle(live_angle), .live_valid(live_valid),
        .inh_n(inh_n), .en_hi_n(en_hi_n), .en_lo_n(en_lo_n), .bus_dout(bus_dout),
        .bus_oe(bus_oe), .bus_conflict(bus_conflict), .track_word(track_word));

    angle_hold_bus #(.ANGLE_W(12), .INH_LAT(INH_LAT), .EN_LAT(EN_LAT), .DIS_LAT(DIS_LAT)) dut12 (
        .clk(clk), .rst_n(rst_n), .live_angle(live12), .live_valid(valid12),
        .inh_n(inh12_n), .en_hi_n(en_hi12_n), .en_lo_n(en_lo12_n), .bus_dout(dout12),
        .bus_oe(oe12), .bus_conflict(conf12), .track_word(track12));

    // History of the newest complete word at each edge (from R2/R3/R5).
    int ecount = 0;
    logic [W-1:0] last_w = '0;
    logic [W-1:0] hist [64];

    always @(posedge clk) begin
        ecount = ecount + 1;
        if (!rst_n) last_w = '0;
        else if (live_valid) last_w = live_angle;
        hist[ecount % 64] = last_w;
    end

    always @(negedge clk) begin
        if (stream_on) begin
            live_valid <= ($urandom % 4) != 0;
            live_angle <= W'($urandom);
        end else begin
            live_valid <= 1'b0;
        end
    end

    function automatic logic [7:0] hi_of(input logic [W-1:0] w);
        return w[15:8];
    endfunction

    function automatic logic [7:0] lo_of(input logic [W-1:0] w);
        return w[7:0];
    endfunction

    function automatic logic [W-1:0] hist_at(input int e);
        return hist[e % 64];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(10 * 150000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=done", ecount);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [W-1:0] snap;
        int n;
        void'($urandom(32'd2024));
        rst_n = 1'b0; inh_n = 1'b1; en_hi_n = 1'b1; en_lo_n = 1'b1;
        live_angle = '0; live_valid = 1'b0;
        live12 = '0; valid12 = 1'b0; inh12_n = 1'b1; en_hi12_n = 1'b1; en_lo12_n = 1'b1;
        for (int i = 0; i < 64; i++) hist[i] = '0;
        tick(3);
        check("R1 oe in reset", 32'(bus_oe), 0);
        rst_n = 1'b1;
        tick(1);
        check("R1 oe", 32'(bus_oe), 0);
        check("R1 dout", 32'(bus_dout), 0);
        check("R1 conflict", 32'(bus_conflict), 0);
        check("R1 track", 32'(track_word), 0);

        tick(5);
        check("R7 idle oe", 32'(bus_oe), 0);
        check("R7 idle dout", 32'(bus_dout), 0);

        stream_on = 1'b1;
        tick(4);
        en_hi_n = 1'b0;
        tick(EN_LAT + 2);
        for (int i = 0; i < 6; i++) begin
            tick(1);
            check("R2 transparent hi", 32'(bus_dout), 32'(hi_of(hist_at(ecount - 1))));
            check("R3 track", 32'(track_word), 32'(hist_at(ecount)));
        end

        n = ecount;
        inh_n = 1'b0;
        tick(INH_LAT);
        snap = hist_at(n + INH_LAT - 1);
        check("R5 inhibit latency", 32'(bus_dout), 32'(hi_of(snap)));
        for (int i = 0; i < 6; i++) begin
            tick(1);
            check("R4 held hi", 32'(bus_dout), 32'(hi_of(snap)));
            check("R3 track under inhibit", 32'(track_word), 32'(hist_at(ecount)));
        end
        en_hi_n = 1'b1; en_lo_n = 1'b0;
        tick(1);
        check("R4 same-sample lo", 32'(bus_dout), 32'(lo_of(snap)));
        check("R8 oe kept on swap", 32'(bus_oe), 1);

        inh_n = 1'b1;
        tick(INH_LAT + 1);
        check("R2 transparent lo", 32'(bus_dout), 32'(lo_of(hist_at(ecount - 1))));

        en_lo_n = 1'b1;
        tick(DIS_LAT - 1);
        check("R9 still driving", 32'(bus_oe), 1);
        tick(1);
        check("R9 floated", 32'(bus_oe), 0);
        check("R7 dout zero", 32'(bus_dout), 0);

        tick(4);
        en_lo_n = 1'b0;
        tick(EN_LAT - 1);
        check("R8 not early", 32'(bus_oe), 0);
        tick(1);
        check("R8 driving", 32'(bus_oe), 1);
        check("R8 data valid", 32'(bus_dout), 32'(lo_of(hist_at(ecount - 1))));

        en_hi_n = 1'b0;
        #1;
        check("R10 conflict flag", 32'(bus_conflict), 1);
        tick(1);
        check("R10 hi wins", 32'(bus_dout), 32'(hi_of(hist_at(ecount - 1))));
        en_lo_n = 1'b1;
        #1;
        check("R10 single enable", 32'(bus_conflict), 0);
        en_hi_n = 1'b1;
        tick(DIS_LAT + 1);

        live12 = 12'hA5C; valid12 = 1'b1;
        tick(1);
        valid12 = 1'b0; en_lo12_n = 1'b0;
        tick(EN_LAT + 2);
        check("R6 low byte left-justified", 32'(dout12), 32'h00C0);
        en_lo12_n = 1'b1; en_hi12_n = 1'b0;
        tick(1);
        check("R6 high byte", 32'(dout12), 32'h00A5);
        en_hi12_n = 1'b1;
        check("R6 full-width low", 32'(lo_of(hist_at(ecount))), 32'(hist_at(ecount) & 16'h00FF));

        for (int it = 0; it < 24; it++) begin
            bit hi_first;
            n = ecount;
            inh_n = 1'b0;
            tick(INH_LAT);
            snap = hist_at(n + INH_LAT - 1);
            hi_first = 1'($urandom % 2);
            if (hi_first) en_hi_n = 1'b0; else en_lo_n = 1'b0;
            tick(EN_LAT);
            check("R8 random enable", 32'(bus_oe), 1);
            check("R4 random first byte", 32'(bus_dout),
                  32'(hi_first ? hi_of(snap) : lo_of(snap)));
            en_hi_n = hi_first; en_lo_n = !hi_first;
            tick(1);
            check("R4 random second byte", 32'(bus_dout),
                  32'(hi_first ? lo_of(snap) : hi_of(snap)));
            en_hi_n = 1'b1; en_lo_n = 1'b1;
            tick(DIS_LAT);
            check("R9 random float", 32'(bus_oe), 0);
            inh_n = 1'b1;
            tick(2 + int'($urandom % 4));
            check("R7 random idle", 32'(bus_dout), 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule